// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit processor core and a memory bus whose data word is split into byte lanes. On the store side it takes a register value, an access size and the low address bits. It returns the bus write word with the narrow value copied into every lane, plus a byte-enable mask that selects only the addressed bytes. The surrounding memory merges the enabled bytes and leaves the other bytes as they were. On the load side it takes the returned bus word and picks the addressed byte or halfword. It then fills the upper bits with copies of the sign bit or with zeros and registers the result. A done strobe marks the cycle in which that result is valid.

The lane order is little-endian: byte lane n carries data bits [8n+7:8n]. The unit flags misaligned accesses and does not split or repair them. It raises no exceptions and does no pipeline control.

The store side is purely combinational. The load side accepts a qualifier, `ld_valid`, which is asserted in every cycle that `bus_rdata` holds a word to convert. The unit has no ready output, so there is no back-pressure. It accepts one load per cycle, including back-to-back loads, and the consumer must take every `ld_done` pulse in the cycle it appears.

Top module: `lane_align_unit`

## Requirements
- R1: A byte store (size code 2'b00) puts bits [7:0] of `st_data` into all four lanes of `bus_wdata`. It drives `bus_be` one-hot, with bit `st_addr` set.
- R2: A halfword store (size code 2'b01) with `st_addr[0]`=0 puts bits [15:0] of `st_data` into both halfword lanes. It drives `bus_be` to 4'b0011 when `st_addr[1]`=0 and to 4'b1100 when `st_addr[1]`=1.
- R3: A word store (size code 2'b10) with `st_addr`=2'b00 passes `st_data` unchanged and drives `bus_be` to 4'b1111.
- R4: An access is misaligned in each of these cases:
  - a halfword access with address bit 0 set;
  - a word access with nonzero address bits;
  - any access with the reserved size code 2'b11.
  A misaligned store raises `st_misalign` and drives `bus_be` to 4'b0000. A misaligned load raises `ld_misalign` with its done strobe and returns `ld_data`=0.
- R5: A byte load returns lane `ld_addr` of `bus_rdata` (bits [8n+7:8n]). When `ld_signed`=1 the result is sign-extended from bit 7; when `ld_signed`=0 it is zero-extended.
- R6: An aligned halfword load returns bits [15:0] of `bus_rdata` when `ld_addr[1]`=0 and bits [31:16] when it is 1. The result is sign-extended when `ld_signed`=1 and zero-extended when `ld_signed`=0.
- R7: An aligned word load returns `bus_rdata` unchanged, whatever the value of `ld_signed`.
- R8: `ld_done` is high exactly in the cycle after a cycle with `ld_valid` high. `ld_data` and `ld_misalign` reflect the inputs captured at that edge, and back-to-back loads give back-to-back results.
- R9: While `rst_n` is low, `ld_done`, `ld_data` and `ld_misalign` are all zero.
- R10: Merging two halfword stores into one memory word under their byte enables preserves the other halfword. Storing 0xCAFEFACE at offset 0 and then 0x12345678 at offset 2 leaves 0x5678FACE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_size | input | 2 | Store size: 00 byte, 01 halfword, 10 word, 11 reserved |
| st_addr | input | 2 | Low address bits of the store |
| st_data | input | 32 | Register value to store |
| bus_wdata | output | 32 | Lane-replicated write data |
| bus_be | output | 4 | Byte enables, bit n for lane n |
| st_misalign | output | 1 | Store is misaligned or uses the reserved size code |
| ld_valid | input | 1 | `bus_rdata` holds a load word this cycle |
| ld_size | input | 2 | Load size, same encoding as `st_size` |
| ld_signed | input | 1 | 1 = sign-extend, 0 = zero-extend |
| ld_addr | input | 2 | Low address bits of the load |
| bus_rdata | input | 32 | Word returned by the bus |
| ld_done | output | 1 | Registered load result valid |
| ld_data | output | 32 | Extracted and extended load result |
| ld_misalign | output | 1 | Registered misalignment flag for the load |

## Verification
The embedded properties assume that `ld_valid` is held low for the whole of reset. They also assume that the size, address and signedness inputs carry known values whenever they are sampled, since the store properties look at the store inputs in every cycle. The stimulus keeps to this: it drives every input to a defined value before reset is released and changes inputs only on the falling clock edge, so each rising edge sees settled values. The sweep covers every combination of size code, address offset and signedness across data patterns with set and clear sign bits in each lane. Misaligned and reserved cases therefore reach the properties as ordinary inputs, never as unknowns.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lane_align_check.sv
module lane_align_check
  import lane_align_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic [1:0]    size,
  input  logic [AW-1:0] addr,
  output logic          misalign
);
  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = addr[0];
      SZ_WORD: misalign = |addr;
      default: misalign = 1'b1;
    endcase
  end
endmodule

// File: rtl/store_lane_pack.sv
module store_lane_pack
  import lane_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]              size,
  input  logic [$clog2(DATA_W/8)-1:0] addr,
  input  logic                    misalign,
  input  logic [DATA_W-1:0]       data,
  output logic [DATA_W-1:0]       wdata,
  output logic [DATA_W/8-1:0]     be
);
  localparam int LANES = DATA_W / 8;
  localparam int AW    = $clog2(LANES);

  // Lane replication: each lane picks its byte from the narrow value.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case (acc_size_e'(size))
        SZ_BYTE: wdata[8*g +: 8] = data[7:0];
        SZ_HALF: wdata[8*g +: 8] = data[8*(g%2) +: 8];
        default: wdata[8*g +: 8] = data[8*g +: 8];
      endcase
    end
  end

  logic [AW-1:0] half_base;
  assign half_base = {addr[AW-1:1], 1'b0};

  always_comb begin
    if (misalign) begin
      be = '0;
    end else begin
      unique case (acc_size_e'(size))
        SZ_BYTE: be = LANES'(1) << addr;
        SZ_HALF: be = LANES'(3) << half_base;
        default: be = '1;
      endcase
    end
  end
endmodule

// File: rtl/load_lane_extract.sv
module load_lane_extract
  import lane_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        valid,
  input  logic [1:0]                  size,
  input  logic                        sgn,
  input  logic [$clog2(DATA_W/8)-1:0] addr,
  input  logic                        misalign,
  input  logic [DATA_W-1:0]           rdata,
  output logic                        done,
  output logic [DATA_W-1:0]           result,
  output logic                        err
);
  localparam int LANES = DATA_W / 8;
  localparam int AW    = $clog2(LANES);

  logic [7:0]        sel_byte;
  logic [15:0]       sel_half;
  logic [DATA_W-1:0] ext;
  logic [AW-1:0]     half_base;

  assign half_base = {addr[AW-1:1], 1'b0};
  assign sel_byte  = rdata[8*addr +: 8];
  assign sel_half  = rdata[8*half_base +: 16];

  always_comb begin
    if (misalign) begin
      ext = '0;
    end else begin
      unique case (acc_size_e'(size))
        SZ_BYTE: ext = {{(DATA_W-8){sgn & sel_byte[7]}}, sel_byte};
        SZ_HALF: ext = {{(DATA_W-16){sgn & sel_half[15]}}, sel_half};
        default: ext = rdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
      err    <= 1'b0;
    end else begin
      done <= valid;
      if (valid) begin
        result <= ext;
        err    <= misalign;
      end
    end
  end
endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
  import lane_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int AW    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        st_size,
  input  logic [AW-1:0]     st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [LANES-1:0]  bus_be,
  output logic              st_misalign,
  input  logic              ld_valid,
  input  logic [1:0]        ld_size,
  input  logic              ld_signed,
  input  logic [AW-1:0]     ld_addr,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              ld_done,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_misalign
);
  logic ld_bad;

  lane_align_check #(.AW(AW)) u_st_chk (
    .size(st_size), .addr(st_addr), .misalign(st_misalign)
  );

  lane_align_check #(.AW(AW)) u_ld_chk (
    .size(ld_size), .addr(ld_addr), .misalign(ld_bad)
  );

  store_lane_pack #(.DATA_W(DATA_W)) u_pack (
    .size(st_size), .addr(st_addr), .misalign(st_misalign),
    .data(st_data), .wdata(bus_wdata), .be(bus_be)
  );

  load_lane_extract #(.DATA_W(DATA_W)) u_extract (
    .clk(clk), .rst_n(rst_n), .valid(ld_valid), .size(ld_size),
    .sgn(ld_signed), .addr(ld_addr), .misalign(ld_bad),
    .rdata(bus_rdata), .done(ld_done), .result(ld_data), .err(ld_misalign)
  );

  // Store side
  p_byte_be_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_size == SZ_BYTE) |-> ($countones(bus_be) == 1 && bus_be[st_addr]))
    else $error("p_byte_be_onehot_r1");

  p_half_be_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_size == SZ_HALF && !st_addr[0]) |-> ($countones(bus_be) == 2 &&
      bus_wdata[15:0] == st_data[15:0]))
    else $error("p_half_be_pair_r2");

  p_word_be_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_size == SZ_WORD && st_addr == '0) |-> (bus_be == '1 && bus_wdata == st_data))
    else $error("p_word_be_full_r3");

  p_misalign_no_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_misalign |-> (bus_be == '0))
    else $error("p_misalign_no_be_r4");

  // Load side
  p_misalign_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_done && ld_misalign) |-> (ld_data == '0))
    else $error("p_misalign_zero_r4");

  p_byte_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_size == SZ_BYTE && ld_signed) |=>
      ($countones(ld_data[DATA_W-1:7]) == 0 || $countones(ld_data[DATA_W-1:7]) == DATA_W-7))
    else $error("p_byte_sext_r5");

  p_word_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_size == SZ_WORD && ld_addr == '0) |=> (ld_data == $past(bus_rdata)))
    else $error("p_word_pass_r7");

  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> ld_done)
    else $error("p_done_follows_r8");

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !ld_done)
    else $error("p_done_idle_r8");
endmodule

// File: tb/lane_align_unit_test.sv
module lane_align_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  st_size = '0;
  logic [1:0]  st_addr = '0;
  logic [31:0] st_data = '0;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_be;
  logic        st_misalign;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_size = '0;
  logic        ld_signed = 1'b0;
  logic [1:0]  ld_addr = '0;
  logic [31:0] bus_rdata = '0;
  logic        ld_done;
  logic [31:0] ld_data;
  logic        ld_misalign;

  int checks = 0;
  int fails  = 0;
  bit over   = 0;

  always #2 clk = ~clk;

  lane_align_unit uut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic bit exp_err(input int sz, input int a);
    case (sz)
      0: return 1'b0;
      1: return a[0];
      2: return a != 0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [3:0] exp_be(input int sz, input int a);
    if (exp_err(sz, a)) return 4'h0;
    case (sz)
      0: return 4'(1 << a);
      1: return (a >= 2) ? 4'hC : 4'h3;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [31:0] exp_wd(input int sz, input logic [31:0] d);
    case (sz)
      0: return {4{d[7:0]}};
      1: return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] exp_ld(input int sz, input bit s, input int a,
                                         input logic [31:0] d);
    logic [31:0] v;
    if (exp_err(sz, a)) return 32'h0;
    case (sz)
      0: begin
        v = (d >> (8 * a)) & 32'hFF;
        if (s && v[7]) v = v | 32'hFFFF_FF00;
        return v;
      end
      1: begin
        v = (d >> (16 * (a / 2))) & 32'hFFFF;
        if (s && v[15]) v = v | 32'hFFFF_0000;
        return v;
      end
      default: return d;
    endcase
  endfunction

  function automatic string req_of(input int sz, input bit store);
    if (sz == 3) return "R4";
    if (store) return (sz == 0) ? "R1" : (sz == 1) ? "R2" : "R3";
    return (sz == 0) ? "R5" : (sz == 1) ? "R6" : "R7";
  endfunction

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
    finish_run();
  end

  logic [31:0] pats [4] = '{32'h80FF_7F01, 32'h7F80_01FE, 32'hCAFE_FACE, 32'h1234_5678};

  initial begin
    logic [31:0] mem;
    // R9 reset state
    repeat (3) @(negedge clk);
    check(ld_done == 0 && ld_data == 0 && ld_misalign == 0, "R9",
          {ld_done, ld_misalign, 30'b0} | ld_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Store sweep: R1 R2 R3 R4
    for (int p = 0; p < 4; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int a = 0; a < 4; a++) begin
          @(negedge clk);
          st_size = 2'(sz); st_addr = 2'(a); st_data = pats[p];
          #1;
          check(bus_be == exp_be(sz, a),
                exp_err(sz, a) ? "R4" : req_of(sz, 1), 32'(bus_be), 32'(exp_be(sz, a)));
          check(st_misalign == exp_err(sz, a), "R4", 32'(st_misalign), 32'(exp_err(sz, a)));
          if (!exp_err(sz, a))
            check(bus_wdata == exp_wd(sz, pats[p]), req_of(sz, 1), bus_wdata,
                  exp_wd(sz, pats[p]));
        end

    // R10 halfword merge preserves the other half
    mem = 32'h0;
    @(negedge clk); st_size = 2'd1; st_addr = 2'd0; st_data = 32'hCAFE_FACE; #1;
    for (int b = 0; b < 4; b++) if (bus_be[b]) mem[8*b +: 8] = bus_wdata[8*b +: 8];
    @(negedge clk); st_size = 2'd1; st_addr = 2'd2; st_data = 32'h1234_5678; #1;
    for (int b = 0; b < 4; b++) if (bus_be[b]) mem[8*b +: 8] = bus_wdata[8*b +: 8];
    check(mem == 32'h5678_FACE, "R10", mem, 32'h5678_FACE);

    // Load sweep: R4 R5 R6 R7 R8
    for (int p = 0; p < 4; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int a = 0; a < 4; a++)
          for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            ld_valid = 1; ld_size = 2'(sz); ld_addr = 2'(a); ld_signed = s[0];
            bus_rdata = pats[p];
            @(negedge clk);
            ld_valid = 0; bus_rdata = 32'hDEAD_0000;
            check(ld_done == 1, "R8", 32'(ld_done), 32'h1);
            check(ld_data == exp_ld(sz, s[0], a, pats[p]),
                  exp_err(sz, a) ? "R4" : req_of(sz, 0), ld_data,
                  exp_ld(sz, s[0], a, pats[p]));
            check(ld_misalign == exp_err(sz, a), "R4", 32'(ld_misalign),
                  32'(exp_err(sz, a)));
          end

    // R8: idle cycle drops done; back-to-back loads
    @(negedge clk);
    check(ld_done == 0, "R8", 32'(ld_done), 32'h0);
    ld_valid = 1; ld_size = 2'd0; ld_addr = 2'd3; ld_signed = 1; bus_rdata = 32'h8000_0000;
    @(negedge clk);
    check(ld_done == 1 && ld_data == 32'hFFFF_FF80, "R8", ld_data, 32'hFFFF_FF80);
    ld_size = 2'd1; ld_addr = 2'd2; ld_signed = 0; bus_rdata = 32'hBEEF_0000;
    @(negedge clk);
    check(ld_done == 1 && ld_data == 32'h0000_BEEF, "R8", ld_data, 32'h0000_BEEF);
    ld_valid = 0;
    @(negedge clk);
    check(ld_done == 0, "R8", 32'(ld_done), 32'h0);

    // R9: reset again clears registered outputs
    ld_valid = 1; ld_size = 2'd2; ld_addr = 2'd0; bus_rdata = 32'hFFFF_FFFF;
    @(negedge clk);
    ld_valid = 0;
    rst_n = 0;
    #1;
    check(ld_done == 0 && ld_data == 0 && ld_misalign == 0, "R9", ld_data, 32'h0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    finish_run();
  end
endmodule